// File: doc/BRIEF.md
# Addressed Packet Receive Framer

This block assembles one packet from a stream of bytes delivered by a serial byte receiver on a shared wire. Each byte arrives with a one-cycle valid strobe. Any byte-level fault in the receiver is reported with a one-cycle error strobe. A start pulse arms the framer. The first byte names the destination. The framer accepts it when it matches the configured node address or the all-ones broadcast value. An accept-all input turns that filter off.

The second byte gives the payload length. It is compared against a configured limit. The framer then takes exactly length plus one further bytes, the extra one being a trailing check byte. Every accepted byte goes out through a registered address/data write port into an external buffer, starting at address 0. One done pulse ends each armed packet. It carries a success flag and a two-bit cause. Checksum verification and bus arbitration belong to other blocks.

Top module: `pkt_rx_framer`

## Requirements
- R1: After reset the framer is idle: `busy`, `done` and `wr_en` are all low.
- R2: When the first byte after arming equals `node_addr` or 0xFF, it is written to buffer address 0.
- R3: While `accept_all` is high, any first byte is accepted and written to address 0.
- R4: A first byte that is rejected by the filter causes no write. It ends the packet with `done` high, `done_ok` low and `done_code` = 1 (not for this node).
- R5: The second byte is always written to address 1. If its value is greater than or equal to `max_len`, the packet ends with `done_ok` low and `done_code` = 2 (too long). This happens in the same cycle as that write.
- R6: If the length L is below `max_len`, exactly L+1 further bytes are written to addresses 2 through L+2. The last of these writes coincides with `done` high, `done_ok` high and `done_code` = 0.
- R7: An error strobe at any stage of an armed packet causes no write. It ends the packet with `done_ok` low and `done_code` = 3 (byte error).
- R8: After `done`, byte and error strobes produce no writes and no further `done` until the next start pulse.
- R9: `done` lasts exactly one cycle. `done_ok` is high with `done` only when `done_code` is 0.
- R10: A start pulse, even in the middle of a packet, restarts framing. A byte strobe in that same cycle is ignored, and the next accepted byte is written to address 0.
- R11: A write and a `done` each appear one cycle after the strobe that caused them. `busy` is high from the cycle after start until the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm pulse; restarts framing |
| node_addr | input | 8 | Configured address of this node |
| max_len | input | 8 | Length limit; lengths at or above it are rejected |
| accept_all | input | 1 | Disables destination filtering |
| rx_valid | input | 1 | Received byte strobe |
| rx_err | input | 1 | Byte-level receive error strobe |
| rx_data | input | 8 | Received byte |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | BUF_AW | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Packet received successfully |
| done_code | output | 2 | 0 none, 1 not for node, 2 too long, 3 byte error |
| busy | output | 1 | Framer armed and collecting |

## Verification
The bench builds the framer with the default BUF_AW of 9. At that width the largest packet the length rule allows, 254 payload bytes plus the header and check byte, fits without the address wrapping. The bench varies `max_len` from one test to the next, using small limits such as 4 and 16. This puts the limit boundary within a few bytes: a length one below the limit is accepted and a length equal to it is refused. A length of zero is used to show that a lone check byte still completes the packet.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] BCAST_ADDR = '1;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DEST = 2'd1,
        FR_LEN  = 2'd2,
        FR_BODY = 2'd3
    } fr_state_e;

    typedef enum logic [1:0] {
        END_NONE     = 2'd0,
        END_NOT_ME   = 2'd1,
        END_TOO_LONG = 2'd2,
        END_BYTE_ERR = 2'd3
    } end_code_e;

    typedef struct packed {
        logic      fire;
        logic      ok;
        end_code_e code;
    } fr_result_t;

    function automatic fr_result_t finish(input end_code_e c);
        fr_result_t r;
        r.fire = 1'b1;
        r.ok   = (c == END_NONE);
        r.code = c;
        return r;
    endfunction

endpackage

// File: rtl/pkt_rx_addr_match.sv
module pkt_rx_addr_match
    import pkt_rx_pkg::*;
(
    input  logic [BYTE_W-1:0] dest,
    input  logic [BYTE_W-1:0] node_addr,
    input  logic              accept_all,
    output logic              hit
);
    always_comb begin
        hit = accept_all || (dest == node_addr) || (dest == BCAST_ADDR);
    end
endmodule

// File: rtl/pkt_rx_len_gate.sv
module pkt_rx_len_gate
    import pkt_rx_pkg::*;
(
    input  logic [BYTE_W-1:0] len,
    input  logic [BYTE_W-1:0] max_len,
    output logic              too_long,
    output logic [BYTE_W-1:0] tail_count
);
    always_comb begin
        too_long   = (len >= max_len);
        // only used when len < max_len <= all-ones, so len+1 never wraps
        tail_count = len + BYTE_W'(1);
    end
endmodule

// File: rtl/pkt_rx_wr_port.sv
module pkt_rx_wr_port
    import pkt_rx_pkg::*;
#(
    parameter int BUF_AW = 9
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              store,
    input  logic [BYTE_W-1:0] din,
    output logic              wr_en,
    output logic [BUF_AW-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    logic [BUF_AW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (clr) begin
            ptr   <= '0;
            wr_en <= 1'b0;
        end else if (store) begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= din;
            ptr     <= ptr + BUF_AW'(1);
        end else begin
            wr_en <= 1'b0;
        end
    end

    // R10: a clear is never followed by a write in the next cycle
    a_r10_clear_no_write: assert property (@(posedge clk) disable iff (rst)
        clr |=> !wr_en);

    // R6: back-to-back writes without a clear advance the address by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && store && !clr) |=> (wr_en && wr_addr == $past(wr_addr) + BUF_AW'(1)));
endmodule

// File: rtl/pkt_rx_framer.sv
module pkt_rx_framer
    import pkt_rx_pkg::*;
#(
    parameter int BUF_AW = 9
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        node_addr,
    input  logic [7:0]        max_len,
    input  logic              accept_all,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic [7:0]        rx_data,
    output logic              wr_en,
    output logic [BUF_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              done_ok,
    output logic [1:0]        done_code,
    output logic              busy
);
    fr_state_e         state, state_nx;
    logic [BYTE_W-1:0] remain, remain_nx;
    logic              dest_hit, too_long, store;
    logic [BYTE_W-1:0] tail_count;
    fr_result_t        res;

    pkt_rx_addr_match u_match (
        .dest       (rx_data),
        .node_addr  (node_addr),
        .accept_all (accept_all),
        .hit        (dest_hit)
    );

    pkt_rx_len_gate u_len (
        .len        (rx_data),
        .max_len    (max_len),
        .too_long   (too_long),
        .tail_count (tail_count)
    );

    pkt_rx_wr_port #(.BUF_AW(BUF_AW)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .store   (store),
        .din     (rx_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    always_comb begin
        state_nx  = state;
        remain_nx = remain;
        store     = 1'b0;
        res       = '0;
        if (start) begin
            state_nx = FR_DEST;
        end else if (state != FR_IDLE) begin
            if (rx_err) begin
                res = finish(END_BYTE_ERR);
            end else if (rx_valid) begin
                unique case (state)
                    FR_DEST: begin
                        if (dest_hit) begin
                            store    = 1'b1;
                            state_nx = FR_LEN;
                        end else begin
                            res = finish(END_NOT_ME);
                        end
                    end
                    FR_LEN: begin
                        store = 1'b1;
                        if (too_long) begin
                            res = finish(END_TOO_LONG);
                        end else begin
                            remain_nx = tail_count;
                            state_nx  = FR_BODY;
                        end
                    end
                    FR_BODY: begin
                        store     = 1'b1;
                        remain_nx = remain - BYTE_W'(1);
                        if (remain == BYTE_W'(1)) res = finish(END_NONE);
                    end
                    default: ;
                endcase
            end
            if (res.fire) state_nx = FR_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FR_IDLE;
            remain    <= '0;
            done      <= 1'b0;
            done_ok   <= 1'b0;
            done_code <= END_NONE;
        end else begin
            state     <= state_nx;
            remain    <= remain_nx;
            done      <= res.fire;
            done_ok   <= res.fire && res.ok;
            done_code <= res.fire ? res.code : END_NONE;
        end
    end

    assign busy = (state != FR_IDLE);

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: success only with the zero cause
    a_r9_ok_code: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_ok == (done_code == 2'd0)));

    // R8: while idle and not armed, strobes create no write and no done
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (!wr_en && !done));

    // R4: a refused destination is never written
    a_r4_reject_no_write: assert property (@(posedge clk) disable iff (rst)
        (done && done_code == 2'd1) |-> !wr_en);

    // R7: a byte error never writes
    a_r7_err_no_write: assert property (@(posedge clk) disable iff (rst)
        (done && done_code == 2'd3) |-> !wr_en);

    // R11: busy is dropped when done is raised
    a_r11_busy_drop: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(start)) |-> !busy);
endmodule

// File: tb/pkt_rx_framer_test.sv
module pkt_rx_framer_test;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    node_addr = 8'h21;
    logic [7:0]    max_len = 8'd16;
    logic          accept_all = 1'b0;
    logic          rx_valid = 1'b0;
    logic          rx_err = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          done, done_ok, busy;
    logic [1:0]    done_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pkt_rx_framer #(.BUF_AW(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .node_addr(node_addr),
        .max_len(max_len), .accept_all(accept_all), .rx_valid(rx_valid),
        .rx_err(rx_err), .rx_data(rx_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .done_ok(done_ok),
        .done_code(done_code), .busy(busy)
    );

    task automatic check(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic arm();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11 busy after start", busy, 1);
    endtask

    // present one strobe and look at the outputs one edge later
    task automatic feed(input bit err, input logic [7:0] d,
                        input bit exp_wr, input int exp_addr,
                        input bit exp_done, input bit exp_ok,
                        input int exp_code, input string req);
        @(negedge clk);
        rx_valid = !err;
        rx_err   = err;
        rx_data  = d;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_err   = 1'b0;
        check(wr_en == exp_wr, {req, " wr_en"}, wr_en, exp_wr);
        if (exp_wr) begin
            check(wr_addr == exp_addr, {req, " wr_addr"}, wr_addr, exp_addr);
            check(wr_data == d, {req, " wr_data"}, wr_data, d);
        end
        check(done == exp_done, {req, " done"}, done, exp_done);
        if (exp_done) begin
            check(done_ok == exp_ok, {req, " done_ok"}, done_ok, exp_ok);
            check(done_code == exp_code, {req, " done_code"}, done_code, exp_code);
            check(busy == 1'b0, "R11 busy low at done", busy, 0);
        end
    endtask

    task automatic after_done();
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", done, 0);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(wr_en == 1'b0, "R1 wr_en", wr_en, 0);
    endtask

    task automatic t_own_addr();
        node_addr = 8'h21; max_len = 8'd16; accept_all = 1'b0;
        arm();
        feed(0, 8'h21, 1, 0, 0, 0, 0, "R2 own address");
        feed(0, 8'd3, 1, 1, 0, 0, 0, "R5 length stored");
        feed(0, 8'hA0, 1, 2, 0, 0, 0, "R6 payload 0");
        feed(0, 8'hA1, 1, 3, 0, 0, 0, "R6 payload 1");
        feed(0, 8'hA2, 1, 4, 0, 0, 0, "R6 payload 2");
        feed(0, 8'h5C, 1, 5, 1, 1, 0, "R6 check byte ends");
        after_done();
    endtask

    task automatic t_broadcast_zero_len();
        arm();
        feed(0, 8'hFF, 1, 0, 0, 0, 0, "R2 broadcast");
        feed(0, 8'd0, 1, 1, 0, 0, 0, "R5 zero length");
        feed(0, 8'h77, 1, 2, 1, 1, 0, "R6 lone check byte");
        after_done();
    endtask

    task automatic t_reject();
        arm();
        feed(0, 8'h30, 0, 0, 1, 0, 1, "R4 not for node");
        after_done();
    endtask

    task automatic t_accept_all();
        accept_all = 1'b1;
        arm();
        feed(0, 8'h30, 1, 0, 0, 0, 0, "R3 any destination");
        feed(0, 8'd1, 1, 1, 0, 0, 0, "R3 length");
        feed(0, 8'h11, 1, 2, 0, 0, 0, "R3 payload");
        feed(0, 8'h22, 1, 3, 1, 1, 0, "R3 check byte");
        accept_all = 1'b0;
    endtask

    task automatic t_len_limit();
        max_len = 8'd4;
        arm();
        feed(0, 8'h21, 1, 0, 0, 0, 0, "R5 dest");
        feed(0, 8'd4, 1, 1, 1, 0, 2, "R5 length equal to limit");
        after_done();
        arm();
        feed(0, 8'h21, 1, 0, 0, 0, 0, "R5 dest");
        feed(0, 8'd3, 1, 1, 0, 0, 0, "R5 length below limit");
        for (int i = 0; i < 3; i++) feed(0, 8'(i + 8'h40), 1, 2 + i, 0, 0, 0, "R6 body");
        feed(0, 8'hEE, 1, 5, 1, 1, 0, "R6 check at limit-1");
        max_len = 8'd16;
    endtask

    task automatic t_byte_errors();
        arm();
        feed(1, 8'h21, 0, 0, 1, 0, 3, "R7 error at destination");
        arm();
        feed(0, 8'h21, 1, 0, 0, 0, 0, "R7 dest");
        feed(1, 8'd2, 0, 0, 1, 0, 3, "R7 error at length");
        arm();
        feed(0, 8'h21, 1, 0, 0, 0, 0, "R7 dest");
        feed(0, 8'd2, 1, 1, 0, 0, 0, "R7 length");
        feed(0, 8'h01, 1, 2, 0, 0, 0, "R7 body");
        feed(1, 8'h02, 0, 0, 1, 0, 3, "R7 error in body");
    endtask

    task automatic t_ignore_after_done();
        feed(0, 8'h21, 0, 0, 0, 0, 0, "R8 strobe after done");
        feed(1, 8'h00, 0, 0, 0, 0, 0, "R8 error after done");
        check(busy == 1'b0, "R8 stays idle", busy, 0);
    endtask

    task automatic t_rearm_mid();
        arm();
        feed(0, 8'h21, 1, 0, 0, 0, 0, "R10 first dest");
        feed(0, 8'd5, 1, 1, 0, 0, 0, "R10 first length");
        @(negedge clk);
        start = 1'b1; rx_valid = 1'b1; rx_data = 8'h99;
        @(negedge clk);
        start = 1'b0; rx_valid = 1'b0;
        check(wr_en == 1'b0, "R10 strobe with start ignored", wr_en, 0);
        check(busy == 1'b1, "R10 rearmed", busy, 1);
        feed(0, 8'hFF, 1, 0, 0, 0, 0, "R10 restart at address 0");
        feed(0, 8'd0, 1, 1, 0, 0, 0, "R10 length");
        feed(0, 8'h3C, 1, 2, 1, 1, 0, "R10 completes");
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_own_addr();
        t_broadcast_zero_len();
        t_reject();
        t_accept_all();
        t_len_limit();
        t_byte_errors();
        t_ignore_after_done();
        t_rearm_mid();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule